// File: doc/BRIEF.md
# I2C Transfer Event Flags with Access-Sequenced Clearing

This block holds the transfer event flags of an I2C controller on the register side. It records four events: a START went out in master mode, an address was sent or matched, a byte transfer completed while the clock was stretched, and the header of a 10-bit address went out. The protocol engine and the shifter report these events as single-cycle strobes. A flag stays set until software completes a two-step access ritual. Software first reads status register 0 while the flag is set. It then makes a specific access, either to the data register or to status register 1, depending on the flag. The byte-complete flag can also be cleared by hardware.

The register bus is plain: an address, a read strobe and a write strobe, with read data returned in the same cycle. The data register itself lives elsewhere. This block decodes accesses to it and reports each one on two hook outputs. Status register 1 shows the packet error checking value and the transfer direction, both taken from inputs.

Top module: `i2c_stat_flags`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all flags and arm bits are zero. Both status registers read 0x0000 while pec_val and tx_mode are zero.
- R2: Status register 0 is at offset 0x14. Its bit 0 is start-sent, bit 1 is address, bit 2 is byte-complete and bit 3 is 10-bit header, and bits 15:4 read zero. Read data is zero when bus_rd is low or when the address matches no register.
- R3: ev_start_sent sets the start-sent flag. The flag clears at a data-register write (offset 0x10) only if status register 0 was read earlier while the flag was set.
- R4: ev_addr_done sets the address flag. It clears at a read of status register 1 that follows a read of status register 0 taken while the flag was set. A data-register write leaves it set.
- R5: ev_hdr10_sent sets the 10-bit header flag. It clears by the same status-0-read then data-write sequence as the start-sent flag.
- R6: The byte-complete flag sets only when stretch_en is high and one of two cases holds. Either tx_mode is 0, ev_rx_byte pulses and dreg_full is 1, or tx_mode is 1, ev_tx_byte pulses and dreg_full is 0. In all other cases it does not set.
- R7: The byte-complete flag clears at either a read or a write of the data register, provided that access follows an arming read of status register 0.
- R8: ev_start_sent and ev_stop_sent clear the byte-complete flag. While periph_en is low, the byte-complete flag is held at zero and every arm bit is cleared, so a later completing access with no new status-0 read does not clear any flag.
- R9: A read of status register 0 arms only the flags that are set at that moment. A completing access with no prior arming read clears nothing, and this includes flags that were clear when status register 0 was read.
- R10: A set strobe in the same cycle as a completing access leaves the flag set and drops its arm bit. The next completing access then clears nothing until status register 0 is read again.
- R11: Status register 1 is at offset 0x18. It shows pec_val in bits 15:8, tx_mode in bit 2, and zero elsewhere.
- R12: dat_rd_hook and dat_wr_hook are high in exactly the cycles of a read or write at offset 0x10, and low for every other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | REG_W | Read data, same cycle as bus_rd |
| dat_rd_hook | output | 1 | Data-register read taking place |
| dat_wr_hook | output | 1 | Data-register write taking place |
| periph_en | input | 1 | Peripheral enable level |
| stretch_en | input | 1 | Clock stretching allowed |
| tx_mode | input | 1 | 1 = transmitting, 0 = receiving |
| dreg_full | input | 1 | Data register holds a byte |
| ev_start_sent | input | 1 | START issued in master mode (strobe) |
| ev_stop_sent | input | 1 | STOP issued (strobe) |
| ev_addr_done | input | 1 | Address sent or matched (strobe) |
| ev_hdr10_sent | input | 1 | 10-bit header sent (strobe) |
| ev_rx_byte | input | 1 | Byte landed in shift register (strobe) |
| ev_tx_byte | input | 1 | Shift register emptied (strobe) |
| pec_val | input | PEC_W | Current PEC value |

## Verification
The hardest state to reach is an arm bit that remains set while its flag has already been set again. Only a set strobe that arrives in the same clock as the completing access leads there. The bench drives the strobe and the data write in a single cycle. It then issues a second write without reading status register 0 first, and observes through the status register that the flag survived. The same method checks that a disable pulse removes a pending arm: the bench arms the flag, drops the enable for one cycle, then writes the data register and reads status register 0 back.

// File: rtl/i2c_stf_pkg.sv
package i2c_stf_pkg;

  localparam int NFLAG    = 4;
  localparam int FL_SB    = 0;
  localparam int FL_ADDR  = 1;
  localparam int FL_BTC   = 2;
  localparam int FL_HDR10 = 3;

  typedef logic [NFLAG-1:0] flag_vec_t;

  // which access completes the clear sequence of each flag
  localparam flag_vec_t DONE_ON_DWR  = 4'b1101;
  localparam flag_vec_t DONE_ON_DRD  = 4'b0100;
  localparam flag_vec_t DONE_ON_S1RD = 4'b0010;
  // flags also wiped by START/STOP events and by disable
  localparam flag_vec_t HWCLR_MASK   = 4'b0100;

  typedef struct packed {
    logic s0_rd;
    logic s1_rd;
    logic d_rd;
    logic d_wr;
  } acc_t;

endpackage

// File: rtl/i2c_stf_decode.sv
module i2c_stf_decode
  import i2c_stf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_S0 = 'h14,
  parameter logic [ADDR_W-1:0] OFS_S1 = 'h18,
  parameter logic [ADDR_W-1:0] OFS_D  = 'h10
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output acc_t              acc
);

  logic hit_s0, hit_s1, hit_d;

  always_comb begin
    hit_s0    = (bus_addr == OFS_S0);
    hit_s1    = (bus_addr == OFS_S1);
    hit_d     = (bus_addr == OFS_D);
    acc.s0_rd = bus_rd & hit_s0;
    acc.s1_rd = bus_rd & hit_s1;
    acc.d_rd  = bus_rd & hit_d;
    acc.d_wr  = bus_wr & hit_d;
  end

endmodule

// File: rtl/i2c_stf_btc_cond.sv
module i2c_stf_btc_cond (
  input  logic stretch_en,
  input  logic tx_mode,
  input  logic dreg_full,
  input  logic ev_rx_byte,
  input  logic ev_tx_byte,
  output logic set_o
);

  logic rx_stall, tx_stall;

  always_comb begin
    // receive: new byte waits behind an unread data register
    rx_stall = ~tx_mode & ev_rx_byte & dreg_full;
    // transmit: shifter drained but nothing queued
    tx_stall = tx_mode & ev_tx_byte & ~dreg_full;
    set_o    = stretch_en & (rx_stall | tx_stall);
  end

endmodule

// File: rtl/i2c_stf_flag_cell.sv
module i2c_stf_flag_cell #(
  parameter bit CLR_ON_DIS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic snap_i,
  input  logic done_i,
  input  logic hwclr_i,
  input  logic disable_i,
  output logic flag_o,
  output logic arm_o
);

  logic flag_q, arm_q, flag_d, arm_d;

  always_comb begin
    if (CLR_ON_DIS && disable_i)
      flag_d = 1'b0;
    else
      flag_d = set_i | (flag_q & ~(hwclr_i | (done_i & arm_q)));

    if (disable_i | done_i | hwclr_i)
      arm_d = 1'b0;
    else if (snap_i & flag_q)
      arm_d = 1'b1;
    else
      arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16,
  parameter int PEC_W  = 8,
  parameter logic [ADDR_W-1:0] OFS_S0 = 'h14,
  parameter logic [ADDR_W-1:0] OFS_S1 = 'h18,
  parameter logic [ADDR_W-1:0] OFS_D  = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              dat_rd_hook,
  output logic              dat_wr_hook,
  input  logic              periph_en,
  input  logic              stretch_en,
  input  logic              tx_mode,
  input  logic              dreg_full,
  input  logic              ev_start_sent,
  input  logic              ev_stop_sent,
  input  logic              ev_addr_done,
  input  logic              ev_hdr10_sent,
  input  logic              ev_rx_byte,
  input  logic              ev_tx_byte,
  input  logic [PEC_W-1:0]  pec_val
);

  localparam int S1_TX_BIT = 2;

  acc_t      acc;
  logic      btc_set;
  logic      bus_evt;
  flag_vec_t set_vec, done_vec, flag_q, arm_q;

  i2c_stf_decode #(
    .ADDR_W(ADDR_W), .OFS_S0(OFS_S0), .OFS_S1(OFS_S1), .OFS_D(OFS_D)
  ) u_dec (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .acc(acc)
  );

  i2c_stf_btc_cond u_btc (
    .stretch_en(stretch_en), .tx_mode(tx_mode), .dreg_full(dreg_full),
    .ev_rx_byte(ev_rx_byte), .ev_tx_byte(ev_tx_byte), .set_o(btc_set)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FL_SB]    = ev_start_sent;
    set_vec[FL_ADDR]  = ev_addr_done;
    set_vec[FL_BTC]   = btc_set;
    set_vec[FL_HDR10] = ev_hdr10_sent;
    bus_evt           = ev_start_sent | ev_stop_sent;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign done_vec[i] = (DONE_ON_DWR[i]  & acc.d_wr) |
                         (DONE_ON_DRD[i]  & acc.d_rd) |
                         (DONE_ON_S1RD[i] & acc.s1_rd);

    i2c_stf_flag_cell #(.CLR_ON_DIS(HWCLR_MASK[i])) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_vec[i]), .snap_i(acc.s0_rd), .done_i(done_vec[i]),
      .hwclr_i(HWCLR_MASK[i] & bus_evt), .disable_i(~periph_en),
      .flag_o(flag_q[i]), .arm_o(arm_q[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (acc.s0_rd)
      bus_rdata[NFLAG-1:0] = flag_q;
    if (acc.s1_rd) begin
      bus_rdata[REG_W-1 -: PEC_W] = pec_val;
      bus_rdata[S1_TX_BIT]        = tx_mode;
    end
  end

  assign dat_rd_hook = acc.d_rd;
  assign dat_wr_hook = acc.d_wr;

endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk
  import i2c_stf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_S0 = 'h14,
  parameter logic [ADDR_W-1:0] OFS_S1 = 'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              dat_rd_hook,
  input logic              dat_wr_hook,
  input logic              periph_en,
  input logic              ev_start_sent,
  input logic              ev_stop_sent,
  input logic              ev_addr_done,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  arms
);

  logic rd0, rd1;
  assign rd0 = bus_rd && (bus_addr == OFS_S0);
  assign rd1 = bus_rd && (bus_addr == OFS_S1);

  // R3
  sb_seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_SB]) |-> $past(dat_wr_hook && arms[FL_SB]));

  // R4
  addr_seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_ADDR]) |-> $past(rd1 && arms[FL_ADDR]));

  // R5
  hdr_seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_HDR10]) |-> $past(dat_wr_hook && arms[FL_HDR10]));

  // R7
  btc_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_BTC]) |-> $past((arms[FL_BTC] && (dat_rd_hook || dat_wr_hook))
                                   || ev_start_sent || ev_stop_sent || !periph_en));

  // R8
  disable_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> (!flags[FL_BTC] && arms == '0));

  // R10
  start_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_sent |=> flags[FL_SB]);

  // R10
  addr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_done |=> flags[FL_ADDR]);

  for (genvar i = 0; i < NFLAG; i++) begin : g_arm
    // R9
    arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arms[i]) |-> $past(rd0 && flags[i]));
  end

endmodule

bind i2c_stat_flags i2c_stat_flags_chk #(
  .ADDR_W(ADDR_W), .OFS_S0(OFS_S0), .OFS_S1(OFS_S1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .dat_rd_hook(dat_rd_hook), .dat_wr_hook(dat_wr_hook),
  .periph_en(periph_en), .ev_start_sent(ev_start_sent),
  .ev_stop_sent(ev_stop_sent), .ev_addr_done(ev_addr_done),
  .flags(flag_q), .arms(arm_q)
);

// File: tb/i2c_stat_flags_bench.sv
module i2c_stat_flags_bench;

  localparam logic [7:0] A_S0 = 8'h14;
  localparam logic [7:0] A_S1 = 8'h18;
  localparam logic [7:0] A_D  = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic dat_rd_hook, dat_wr_hook;
  logic periph_en = 1'b1, stretch_en = 1'b1, tx_mode = 1'b0, dreg_full = 1'b0;
  logic ev_start_sent = 1'b0, ev_stop_sent = 1'b0, ev_addr_done = 1'b0;
  logic ev_hdr10_sent = 1'b0, ev_rx_byte = 1'b0, ev_tx_byte = 1'b0;
  logic [7:0] pec_val = '0;

  int checks = 0;
  int errors = 0;
  logic h_rd, h_wr;
  logic [15:0] rd_val;

  always #10 clk = ~clk;

  i2c_stat_flags u_i2c_stat_flags (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .dat_rd_hook(dat_rd_hook),
    .dat_wr_hook(dat_wr_hook), .periph_en(periph_en), .stretch_en(stretch_en),
    .tx_mode(tx_mode), .dreg_full(dreg_full), .ev_start_sent(ev_start_sent),
    .ev_stop_sent(ev_stop_sent), .ev_addr_done(ev_addr_done),
    .ev_hdr10_sent(ev_hdr10_sent), .ev_rx_byte(ev_rx_byte),
    .ev_tx_byte(ev_tx_byte), .pec_val(pec_val)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    d = bus_rdata; h_rd = dat_rd_hook; h_wr = dat_wr_hook;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1;
    #2;
    h_rd = dat_rd_hook; h_wr = dat_wr_hook;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic expect_s0(input logic [15:0] exp, input string req);
    logic [15:0] d;
    rd(A_S0, d);
    check(d, exp, req);
  endtask

  // 0 start, 1 stop, 2 addr, 3 hdr10, 4 rx byte, 5 tx byte, 6 disable
  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: ev_start_sent = 1'b1;
      1: ev_stop_sent  = 1'b1;
      2: ev_addr_done  = 1'b1;
      3: ev_hdr10_sent = 1'b1;
      4: ev_rx_byte    = 1'b1;
      5: ev_tx_byte    = 1'b1;
      default: periph_en = 1'b0;
    endcase
    @(posedge clk); #1;
    ev_start_sent = 1'b0; ev_stop_sent = 1'b0; ev_addr_done = 1'b0;
    ev_hdr10_sent = 1'b0; ev_rx_byte = 1'b0; ev_tx_byte = 1'b0;
    periph_en = 1'b1;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_s0(16'h0000, "R1 stat0 after reset");
    rd(A_S1, rd_val);
    check(rd_val, 16'h0000, "R1 stat1 after reset");
    @(negedge clk);
    check({15'd0, bus_rd ? 1'b1 : 1'b0} | bus_rdata, 16'h0000, "R2 idle read data");
  endtask

  task automatic t_start;
    pulse(0);
    expect_s0(16'h0001, "R3 start flag set");
    wr(A_D);
    expect_s0(16'h0000, "R3 start flag cleared by sequence");
  endtask

  task automatic t_addr;
    pulse(2);
    expect_s0(16'h0002, "R4 address flag set");
    wr(A_D);
    expect_s0(16'h0002, "R4 data write leaves address flag");
    rd(A_S1, rd_val);
    expect_s0(16'h0000, "R4 address flag cleared by stat1 read");
  endtask

  task automatic t_hdr;
    pulse(3);
    expect_s0(16'h0008, "R5 header flag set bit 3");
    wr(A_D);
    expect_s0(16'h0000, "R5 header flag cleared");
  endtask

  task automatic t_btc_set;
    stretch_en = 1'b1; tx_mode = 1'b0; dreg_full = 1'b1;
    pulse(4);
    expect_s0(16'h0004, "R6 rx stall sets byte-complete");
    rd(A_D, rd_val);
    expect_s0(16'h0000, "R7 data read clears byte-complete");
    tx_mode = 1'b1; dreg_full = 1'b0;
    pulse(5);
    expect_s0(16'h0004, "R6 tx stall sets byte-complete");
    wr(A_D);
    expect_s0(16'h0000, "R7 data write clears byte-complete");
    dreg_full = 1'b1;
    pulse(5);
    expect_s0(16'h0000, "R6 tx with full data reg does not set");
    tx_mode = 1'b0; dreg_full = 1'b0;
    pulse(4);
    expect_s0(16'h0000, "R6 rx with empty data reg does not set");
    stretch_en = 1'b0; dreg_full = 1'b1;
    pulse(4);
    expect_s0(16'h0000, "R6 no set without stretching");
    stretch_en = 1'b1;
  endtask

  task automatic t_btc_hw;
    pulse(4);
    pulse(1);
    expect_s0(16'h0000, "R8 stop clears byte-complete");
    pulse(4);
    pulse(0);
    expect_s0(16'h0001, "R8 start clears byte-complete");
    wr(A_D);
    expect_s0(16'h0000, "R3 cleanup");
    pulse(4);
    pulse(6);
    expect_s0(16'h0000, "R8 disable clears byte-complete");
    pulse(0);
    expect_s0(16'h0001, "R8 start armed before disable");
    pulse(6);
    wr(A_D);
    expect_s0(16'h0001, "R8 disable drops arm");
    wr(A_D);
    expect_s0(16'h0000, "R8 cleanup");
  endtask

  task automatic t_no_arm;
    pulse(0);
    wr(A_D);
    expect_s0(16'h0001, "R9 write without arming read");
    wr(A_D);
    expect_s0(16'h0000, "R9 cleanup");
    expect_s0(16'h0000, "R9 read while clear");
    pulse(0);
    wr(A_D);
    expect_s0(16'h0001, "R9 read of clear flag does not arm");
    wr(A_D);
    expect_s0(16'h0000, "R9 cleanup 2");
  endtask

  task automatic t_collide;
    pulse(0);
    expect_s0(16'h0001, "R10 flag set");
    @(negedge clk);
    bus_addr = A_D; bus_wr = 1'b1; ev_start_sent = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; ev_start_sent = 1'b0;
    wr(A_D);
    expect_s0(16'h0001, "R10 set wins and arm dropped");
    wr(A_D);
    expect_s0(16'h0000, "R10 cleanup");
  endtask

  task automatic t_mixed;
    pulse(0);
    pulse(2);
    expect_s0(16'h0003, "R2 two flags together");
    wr(A_D);
    expect_s0(16'h0002, "R2 data write clears start only");
    rd(A_S1, rd_val);
    expect_s0(16'h0000, "R2 stat1 read clears address");
  endtask

  task automatic t_stat1;
    pec_val = 8'hA5; tx_mode = 1'b1;
    rd(A_S1, rd_val);
    check(rd_val, 16'hA504, "R11 stat1 layout");
    tx_mode = 1'b0; pec_val = 8'h3C;
    rd(A_S1, rd_val);
    check(rd_val, 16'h3C00, "R11 stat1 receive");
    rd(8'h20, rd_val);
    check(rd_val, 16'h0000, "R2 unmapped read");
  endtask

  task automatic t_hooks;
    wr(A_D);
    check({14'd0, h_rd, h_wr}, 16'h0001, "R12 data write hook");
    rd(A_D, rd_val);
    check({14'd0, h_rd, h_wr}, 16'h0002, "R12 data read hook");
    rd(A_S0, rd_val);
    check({14'd0, h_rd, h_wr}, 16'h0000, "R12 no hook on stat0");
    wr(A_S1);
    check({14'd0, h_rd, h_wr}, 16'h0000, "R12 no hook on stat1 write");
  endtask

  initial begin
    t_reset;
    t_start;
    t_addr;
    t_hdr;
    t_btc_set;
    t_btc_hw;
    t_no_arm;
    t_collide;
    t_mixed;
    t_stat1;
    t_hooks;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule